// File: doc/BRIEF.md
# Trigger Source and Dwell Timer

This block produces the single trigger pulse of a latching counter system. Three sources feed it. The first is an external trigger input, which is edge-detected. The second is a periodic generator that fires every N microseconds. The third is a software trigger command. The external and periodic sources each pass only while their enable bit is set. The software trigger always passes. When several sources hit in the same cycle, they merge into one single-cycle pulse.

The periodic generator counts microsecond ticks. A parameterised divider derives these ticks from the system clock. N is a 32-bit dwell value, and a value of 0 behaves as 1. Writing the dwell value restarts the period, and so does turning on the periodic enable.

The block also holds a 7-bit control register. This register has three write paths: a direct overwrite, a set-only path and a clear-only path. The block also decodes a command word into one-cycle strobes. A board-reset command clears the control register, the period timer and a free-running microsecond time tag.

Top module: `trig_dwell_top`

## Requirements
- R1: With `regWrEn` high, `regMode` 0 loads `regWrData` into the control register, visible on `ctrlOut` one cycle later. `regMode` 3 leaves the register unchanged.
- R2: `regMode` 1 sets every control bit written as 1 and leaves all other bits unchanged.
- R3: `regMode` 2 clears every control bit written as 1 and leaves all other bits unchanged.
- R4: While control bit 0 is set, the first cycle in which `extTrigIn` is high gives exactly one `trigOut` pulse, one cycle later. Holding the input high gives no further pulse. While bit 0 is clear, the input has no effect on `trigOut`.
- R5: A command write with bit 0 set pulses `trigOut` one cycle later, whatever the enable bits are.
- R6: Command bits 1, 2 and 4 pulse `cntClrOut`, `bufClrOut` and `boardRstOut` respectively, each for one cycle, one cycle after the write. Several of them may be issued in a single write.
- R7: While control bit 1 is set, `trigOut` pulses every N·CLK_PER_US cycles. The first pulse comes N·CLK_PER_US cycles after the edge that wrote the dwell value or turned on bit 1.
- R8: A dwell value of 0 gives the same period as a dwell value of 1.
- R9: Sources that hit in the same cycle produce a single one-cycle `trigOut` pulse.
- R10: A board-reset command (command bit 4) clears the control register, restarts the period timer and zeroes `timeTag`. A control write in the same cycle is ignored.
- R11: `timeTag` increases by one every CLK_PER_US cycles, counted from reset or from the last board-reset edge.
- R12: After reset, `ctrlOut`, `timeTag` and every pulse output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Control register write strobe |
| regMode | input | 2 | 0 direct, 1 set bits, 2 clear bits, 3 no change |
| regWrData | input | 7 | Bit 0 ext enable, bit 1 periodic enable, bit 2 gate port type, bit 3 auto-reset, bits 5:4 gate mode, bit 6 time-tag enable |
| cmdWrEn | input | 1 | Command write strobe |
| cmdData | input | 5 | Bit 0 soft trigger, bit 1 counter clear, bit 2 buffer clear, bit 4 board reset |
| dwellWrEn | input | 1 | Dwell value write strobe |
| dwellWrData | input | DWELL_W | Period N in microseconds |
| extTrigIn | input | 1 | External trigger level |
| trigOut | output | 1 | Merged one-cycle trigger |
| cntClrOut | output | 1 | Counter clear pulse |
| bufClrOut | output | 1 | Buffer clear pulse |
| boardRstOut | output | 1 | Board reset pulse |
| ctrlOut | output | 7 | Control register contents |
| timeTag | output | TAG_W | Microseconds since the last board reset |

## Verification
All results have a latency of one cycle. Control register changes, command pulses and triggers from the external or software source appear one edge after the input is sampled. A periodic trigger appears exactly N·CLK_PER_US edges after the restarting edge. The time tag steps on every CLK_PER_US-th edge after a board reset.

The bench drives its inputs a quarter period after the rising edge. It updates a behavioural model at the rising edge, using edge counts and modulo arithmetic, and compares every output at the falling edge. This means each expected value is sampled in the cycle that follows the edge that produced it. Directed pulse counts over fixed windows cover the held external input, the periodic rate, a dwell value of 0 and coincident sources.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int CTRL_W = 7;
  localparam int CMD_W  = 5;

  // control register bit positions
  localparam int CB_EXT_EN = 0;
  localparam int CB_INT_EN = 1;

  // command word bit positions
  localparam int CMD_SOFT_TRIG = 0;
  localparam int CMD_CNT_CLR   = 1;
  localparam int CMD_BUF_CLR   = 2;
  localparam int CMD_BOARD_RST = 4;

  typedef enum logic [1:0] {
    WR_DIRECT = 2'd0,
    WR_SET    = 2'd1,
    WR_CLEAR  = 2'd2,
    WR_NONE   = 2'd3
  } wrMode_e;

  typedef struct packed {
    logic softTrig;
    logic cntClr;
    logic bufClr;
    logic boardRst;
    logic timerRestart;
  } ctrlStrobes_t;
endpackage

// File: rtl/trig_us_div.sv
module trig_us_div #(
  parameter int DIV = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] divCnt;

  assign tick = run && (divCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      divCnt <= '0;
    else if (clr)   divCnt <= '0;
    else if (run)   divCnt <= tick ? '0 : divCnt + CNT_W'(1);
  end

  // R11: the divider never leaves its range
  p_div_range_r11: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= LAST);
endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
#(
  parameter int DWELL_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regMode,
  input  logic [CTRL_W-1:0]  regWrData,
  input  logic               cmdWrEn,
  input  logic [CMD_W-1:0]   cmdData,
  input  logic               dwellWrEn,
  input  logic [DWELL_W-1:0] dwellWrData,
  output logic [CTRL_W-1:0]  ctrlQ,
  output logic [DWELL_W-1:0] dwellQ,
  output ctrlStrobes_t       strb
);
  logic [CTRL_W-1:0] ctrlWr;
  logic [CTRL_W-1:0] ctrlD;
  logic [CMD_W-1:0]  cmdHit;

  assign cmdHit = cmdWrEn ? cmdData : '0;

  always_comb begin
    unique case (wrMode_e'(regMode))
      WR_DIRECT: ctrlWr = regWrData;
      WR_SET:    ctrlWr = ctrlQ | regWrData;
      WR_CLEAR:  ctrlWr = ctrlQ & ~regWrData;
      default:   ctrlWr = ctrlQ;
    endcase
  end

  always_comb begin
    if (cmdHit[CMD_BOARD_RST]) ctrlD = '0;
    else if (regWrEn)          ctrlD = ctrlWr;
    else                       ctrlD = ctrlQ;
  end

  always_comb begin
    strb.softTrig     = cmdHit[CMD_SOFT_TRIG];
    strb.cntClr       = cmdHit[CMD_CNT_CLR];
    strb.bufClr       = cmdHit[CMD_BUF_CLR];
    strb.boardRst     = cmdHit[CMD_BOARD_RST];
    strb.timerRestart = dwellWrEn | (~ctrlQ[CB_INT_EN] & ctrlD[CB_INT_EN]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      dwellQ <= '0;
    end else begin
      ctrlQ <= ctrlD;
      if (dwellWrEn) dwellQ <= dwellWrData;
    end
  end

  p_direct_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regMode == 2'd0 && !strb.boardRst) |=> ctrlQ == $past(regWrData));

  p_none_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regMode == 2'd3 && !strb.boardRst) |=> $stable(ctrlQ));

  p_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regMode == 2'd1 && !strb.boardRst) |=>
      ((ctrlQ & $past(regWrData)) == $past(regWrData)) &&
      ((ctrlQ & ~$past(regWrData)) == ($past(ctrlQ) & ~$past(regWrData))));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regMode == 2'd2 && !strb.boardRst) |=>
      ((ctrlQ & $past(regWrData)) == '0) &&
      ((ctrlQ & ~$past(regWrData)) == ($past(ctrlQ) & ~$past(regWrData))));

  p_board_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.boardRst |=> ctrlQ == '0);
endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int CLK_PER_US = 5,
  parameter int DWELL_W    = 32,
  parameter int TAG_W      = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extTrigIn,
  input  logic               extEn,
  input  logic               intEn,
  input  logic [DWELL_W-1:0] dwellQ,
  input  ctrlStrobes_t       strb,
  output logic               trigOut,
  output logic               cntClrOut,
  output logic               bufClrOut,
  output logic               boardRstOut,
  output logic [TAG_W-1:0]   timeTag
);
  logic               perTick;
  logic               tagTick;
  logic               perClr;
  logic [DWELL_W-1:0] perCnt;
  logic [DWELL_W-1:0] dwellEff;
  logic               perWrap;
  logic               perHit;
  logic               extPrev;
  logic               extHit;

  assign perClr   = strb.timerRestart | strb.boardRst;
  assign dwellEff = (dwellQ == '0) ? DWELL_W'(1) : dwellQ;
  assign perWrap  = (perCnt == dwellEff - DWELL_W'(1));
  assign perHit   = perTick & perWrap;
  assign extHit   = extEn & extTrigIn & ~extPrev;

  trig_us_div #(.DIV(CLK_PER_US)) perDiv_i (
    .clk (clk),
    .rstN(rstN),
    .clr (perClr),
    .run (intEn),
    .tick(perTick)
  );

  trig_us_div #(.DIV(CLK_PER_US)) tagDiv_i (
    .clk (clk),
    .rstN(rstN),
    .clr (strb.boardRst),
    .run (1'b1),
    .tick(tagTick)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        perCnt <= '0;
    else if (perClr)  perCnt <= '0;
    else if (perTick) perCnt <= perWrap ? '0 : perCnt + DWELL_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              timeTag <= '0;
    else if (strb.boardRst) timeTag <= '0;
    else if (tagTick)       timeTag <= timeTag + TAG_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPrev     <= 1'b0;
      trigOut     <= 1'b0;
      cntClrOut   <= 1'b0;
      bufClrOut   <= 1'b0;
      boardRstOut <= 1'b0;
    end else begin
      extPrev     <= extTrigIn;
      trigOut     <= extHit | perHit | strb.softTrig;
      cntClrOut   <= strb.cntClr;
      bufClrOut   <= strb.bufClr;
      boardRstOut <= strb.boardRst;
    end
  end

  p_soft_trig_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.softTrig |=> trigOut);

  p_cmd_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntClr || strb.bufClr) |=> (cntClrOut || bufClrOut));

  p_ext_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    (extTrigIn && extPrev && !strb.softTrig && !intEn) |=> !trigOut);

  p_period_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    perCnt < dwellEff);

  p_tag_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.boardRst |=> timeTag == '0);

  p_tag_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.boardRst) |->
      (timeTag == $past(timeTag) || timeTag == $past(timeTag) + TAG_W'(1)));
endmodule

// File: rtl/trig_dwell_top.sv
module trig_dwell_top
  import trig_pkg::*;
#(
  parameter int CLK_PER_US = 5,
  parameter int DWELL_W    = 32,
  parameter int TAG_W      = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regMode,
  input  logic [6:0]         regWrData,
  input  logic               cmdWrEn,
  input  logic [4:0]         cmdData,
  input  logic               dwellWrEn,
  input  logic [DWELL_W-1:0] dwellWrData,
  input  logic               extTrigIn,
  output logic               trigOut,
  output logic               cntClrOut,
  output logic               bufClrOut,
  output logic               boardRstOut,
  output logic [6:0]         ctrlOut,
  output logic [TAG_W-1:0]   timeTag
);
  logic [CTRL_W-1:0]  ctrlQ;
  logic [DWELL_W-1:0] dwellQ;
  ctrlStrobes_t       strb;

  trig_ctrl #(.DWELL_W(DWELL_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regMode    (regMode),
    .regWrData  (regWrData),
    .cmdWrEn    (cmdWrEn),
    .cmdData    (cmdData),
    .dwellWrEn  (dwellWrEn),
    .dwellWrData(dwellWrData),
    .ctrlQ      (ctrlQ),
    .dwellQ     (dwellQ),
    .strb       (strb)
  );

  trig_datapath #(
    .CLK_PER_US(CLK_PER_US),
    .DWELL_W   (DWELL_W),
    .TAG_W     (TAG_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .extTrigIn  (extTrigIn),
    .extEn      (ctrlQ[CB_EXT_EN]),
    .intEn      (ctrlQ[CB_INT_EN]),
    .dwellQ     (dwellQ),
    .strb       (strb),
    .trigOut    (trigOut),
    .cntClrOut  (cntClrOut),
    .bufClrOut  (bufClrOut),
    .boardRstOut(boardRstOut),
    .timeTag    (timeTag)
  );

  assign ctrlOut = ctrlQ;
endmodule

// File: tb/trig_dwell_top_tb_top.sv
module trig_dwell_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P_US = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regMode = 2'd0;
  logic [6:0]  regWrData = '0;
  logic        cmdWrEn = 1'b0;
  logic [4:0]  cmdData = '0;
  logic        dwellWrEn = 1'b0;
  logic [31:0] dwellWrData = '0;
  logic        extTrigIn = 1'b0;
  logic        trigOut, cntClrOut, bufClrOut, boardRstOut;
  logic [6:0]  ctrlOut;
  logic [31:0] timeTag;

  int checks = 0;
  int errors = 0;
  int trigCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_dwell_top #(.CLK_PER_US(P_US)) dut_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regMode(regMode), .regWrData(regWrData),
    .cmdWrEn(cmdWrEn), .cmdData(cmdData),
    .dwellWrEn(dwellWrEn), .dwellWrData(dwellWrData),
    .extTrigIn(extTrigIn),
    .trigOut(trigOut), .cntClrOut(cntClrOut), .bufClrOut(bufClrOut),
    .boardRstOut(boardRstOut), .ctrlOut(ctrlOut), .timeTag(timeTag)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, edge counting
  logic [6:0]  mCtrl;
  logic [31:0] mDwell;
  logic        mExtPrev;
  longint      mK, mTagCyc, mKn, mNp;
  logic        eTrig, eCnt, eBuf, eBrd;
  logic [6:0]  mNext;
  logic        mRestart, mPer, mExt;

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = '0; mDwell = '0; mExtPrev = 0; mK = 0; mTagCyc = 0;
      eTrig = 0; eCnt = 0; eBuf = 0; eBrd = 0;
    end else begin
      mNp = ((mDwell == 0) ? 64'd1 : longint'(mDwell)) * P_US;
      mPer = 0;
      mKn = mK + 1;
      if (mCtrl[1]) mPer = ((mKn % mNp) == 0);
      mExt = mCtrl[0] && extTrigIn && !mExtPrev;
      mNext = mCtrl;
      if (regWrEn) begin
        case (regMode)
          2'd0: mNext = regWrData;
          2'd1: mNext = mCtrl | regWrData;
          2'd2: mNext = mCtrl & ~regWrData;
          default: mNext = mCtrl;
        endcase
      end
      if (cmdWrEn && cmdData[4]) mNext = '0;
      mRestart = dwellWrEn || (!mCtrl[1] && mNext[1]) || (cmdWrEn && cmdData[4]);
      if (mRestart) mK = 0;
      else if (mCtrl[1]) mK = mKn;
      eTrig = mExt || mPer || (cmdWrEn && cmdData[0]);
      eCnt  = cmdWrEn && cmdData[1];
      eBuf  = cmdWrEn && cmdData[2];
      eBrd  = cmdWrEn && cmdData[4];
      mTagCyc = (cmdWrEn && cmdData[4]) ? 0 : mTagCyc + 1;
      if (dwellWrEn) mDwell = dwellWrData;
      mExtPrev = extTrigIn;
      mCtrl = mNext;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (trigOut) trigCount++;
      check("trigOut R4 R5 R7 R8 R9", trigOut, eTrig);
      check("cntClrOut R6", cntClrOut, eCnt);
      check("bufClrOut R6", bufClrOut, eBuf);
      check("boardRstOut R6", boardRstOut, eBrd);
      check("ctrlOut R1 R2 R3 R10", ctrlOut, mCtrl);
      check("timeTag R11", timeTag, mTagCyc / P_US);
    end
  end

  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic regWrite(input logic [1:0] mode, input logic [6:0] data);
    step();
    regWrEn = 1; regMode = mode; regWrData = data;
    step();
    regWrEn = 0;
  endtask

  task automatic cmdWrite(input logic [4:0] data);
    step();
    cmdWrEn = 1; cmdData = data;
    step();
    cmdWrEn = 0; cmdData = '0;
  endtask

  task automatic dwellWrite(input logic [31:0] data);
    step();
    dwellWrEn = 1; dwellWrData = data;
    step();
    dwellWrEn = 0;
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    int c0;
    #(CLK_PERIOD*3 + CLK_PERIOD/4);
    // R12 reset state
    check("R12 ctrlOut", ctrlOut, 0);
    check("R12 timeTag", timeTag, 0);
    check("R12 trigOut", trigOut, 0);
    check("R12 boardRstOut", boardRstOut, 0);
    rstN = 1;

    regWrite(2'd0, 7'h55);
    check("R1 direct", ctrlOut, 7'h55);
    regWrite(2'd3, 7'h7f);
    check("R1 no-change mode", ctrlOut, 7'h55);
    regWrite(2'd1, 7'h0A);
    check("R2 set", ctrlOut, 7'h5F);
    regWrite(2'd2, 7'h15);
    check("R3 clear", ctrlOut, 7'h4A);
    regWrite(2'd0, 7'h00);

    // R4 external edge with enable
    regWrite(2'd0, 7'h01);
    c0 = trigCount;
    step(); extTrigIn = 1;
    repeat (5) step();
    extTrigIn = 0;
    repeat (2) step();
    check("R4 held input gives one pulse", trigCount - c0, 1);

    // R4 external ignored when disabled
    regWrite(2'd0, 7'h00);
    c0 = trigCount;
    step(); extTrigIn = 1;
    repeat (3) step();
    extTrigIn = 0;
    repeat (2) step();
    check("R4 disabled input", trigCount - c0, 0);

    // R5 software trigger with all enables clear
    c0 = trigCount;
    cmdWrite(5'h01);
    repeat (2) step();
    check("R5 soft trigger", trigCount - c0, 1);

    // R6 several commands in one write
    cmdWrite(5'h06);
    step();

    // R7 periodic, N=3
    dwellWrite(32'd3);
    c0 = trigCount;
    regWrite(2'd0, 7'h02);
    repeat (38) step();
    check("R7 three periods", trigCount - c0, 3);

    // R8 dwell 0 acts as 1
    c0 = trigCount;
    dwellWrite(32'd0);
    repeat (10) step();
    check("R8 dwell zero", trigCount - c0, 2);

    // R9 coincident external and soft trigger
    regWrite(2'd0, 7'h01);
    repeat (2) step();
    c0 = trigCount;
    step();
    extTrigIn = 1; cmdWrEn = 1; cmdData = 5'h01;
    step();
    cmdWrEn = 0; cmdData = '0;
    repeat (3) step();
    extTrigIn = 0;
    step();
    check("R9 merged pulse", trigCount - c0, 1);

    // R10 board reset together with a control write
    regWrite(2'd0, 7'h7f);
    repeat (7) step();
    step();
    cmdWrEn = 1; cmdData = 5'h10;
    regWrEn = 1; regMode = 2'd0; regWrData = 7'h33;
    step();
    cmdWrEn = 0; cmdData = '0; regWrEn = 0;
    check("R10 ctrl cleared", ctrlOut, 0);
    check("R10 tag cleared", timeTag, 0);
    repeat (9) step();
    check("R11 tag after 9 cycles", timeTag, 9 / P_US);
    repeat (3) step();
    check("R11 tag after 12 cycles", timeTag, 12 / P_US);

    finishRun();
  end
endmodule